// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst, one beat per clock. A four-bit mode value is written through a load strobe. Its low three bits pick the burst length and bit 3 picks the beat ordering. A start strobe carries the first column address of a burst. From the next cycle the block steps through the burst and drives the column address, a valid flag and a last-beat flag.

Beats never leave the burst-aligned window. Only the low one, two or three address bits change, and a sequential increment wraps inside the window instead of carrying into the higher column bits. A start issued while the stored mode holds a reserved length code gives no beats and raises an illegal-mode flag instead. The block leaves command timing, data capture, latency and refresh to its neighbours.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset drops valid_o, last_o and illegal_o and sets the stored length code to the reserved value 000. A start issued after reset with no load is therefore reported as illegal.
- R2: The length code in mode bits [2:0] is decoded as 001 = 2 beats, 010 = 4 beats and 011 = 8 beats. After an accepted start, valid_o is high for exactly that many consecutive cycles.
- R3: The length codes 000, 100, 101, 110 and 111 are reserved. A start with a reserved stored code raises illegal_o for exactly one cycle, in the cycle after the start, and valid_o stays low.
- R4: With mode bit 3 = 0 (sequential order), beat i carries the start address with its low log2(BL) bits replaced by (start low bits + i) modulo BL.
- R5: With mode bit 3 = 1 (interleaved order), beat i carries the start address with its low log2(BL) bits replaced by (start low bits XOR i).
- R6: Column bits above the burst window keep their start values on every beat. An increment never carries out of the window.
- R7: A mode load is taken only while no burst is running, that is while valid_o is low. A load during a burst has no effect on the length or order of any later burst.
- R8: A start strobe while valid_o is high is ignored, and the running burst continues unchanged.
- R9: Beat 0 appears in the cycle after the clock edge that samples start_i. last_o is high only on the final beat, and valid_o falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mr_load_i | input | 1 | Mode-value write strobe |
| mr_value_i | input | 4 | Mode value: [2:0] length code, [3] order select |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W | First column address of the burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat |
| illegal_o | output | 1 | Start refused because of a reserved length code |

## Verification
The mode register, the beat counter and the flags are each one register stage deep. Every result therefore belongs to a fixed cycle: beat i is due i+1 cycles after the edge that samples start_i, and the illegal pulse is due one cycle after that edge. The bench drives inputs on falling edges and compares outputs on the next falling edge, beat by beat, against expected addresses it computes itself. It also checks that valid_o is low in the cycle after the final beat, which confirms the length. Ignored loads and starts are placed in the middle of a burst. Their absence of effect is then checked on the remaining beats and on the length of a later burst started without a fresh load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   // Widest burst is 8 beats, so the wrap window is 3 address bits.
   localparam int WIN_W = 3;

   typedef struct packed {
      logic             legal;
      logic             interleave;
      logic [WIN_W-1:0] last_idx;
      logic [WIN_W-1:0] mask;
   } bmode_t;

   function automatic bmode_t decode_mode(input logic [3:0] field);
      bmode_t m;
      m.interleave = field[3];
      m.legal      = 1'b1;
      unique case (field[2:0])
         3'b001: begin m.last_idx = 3'd1; m.mask = 3'b001; end
         3'b010: begin m.last_idx = 3'd3; m.mask = 3'b011; end
         3'b011: begin m.last_idx = 3'd7; m.mask = 3'b111; end
         default: begin
            m.legal    = 1'b0;
            m.last_idx = '0;
            m.mask     = '0;
         end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
   import bseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load_i,
   input  logic       busy_i,
   input  logic [3:0] value_i,
   output bmode_t     mode_o
);

   logic [3:0] field_q;

   // Loads are refused while a burst runs; reset lands on reserved code 000.
   always_ff @(posedge clk) begin
      if (rst)
         field_q <= 4'b0000;
      else if (load_i && !busy_i)
         field_q <= value_i;
   end

   always_comb mode_o = decode_mode(field_q);

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
   import bseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  bmode_t           mode_i,
   output logic             capture_o,
   output logic [WIN_W-1:0] beat_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             illegal_o
);

   logic             valid_q;
   logic             illegal_q;
   logic [WIN_W-1:0] beat_q;
   logic             accept;

   assign accept    = start_i && !valid_q;
   assign capture_o = accept && mode_i.legal;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q   <= 1'b0;
         illegal_q <= 1'b0;
         beat_q    <= '0;
      end else begin
         illegal_q <= accept && !mode_i.legal;
         if (capture_o) begin
            valid_q <= 1'b1;
            beat_q  <= '0;
         end else if (valid_q) begin
            if (beat_q == mode_i.last_idx) begin
               valid_q <= 1'b0;
               beat_q  <= '0;
            end else begin
               beat_q  <= beat_q + 1'b1;
            end
         end
      end
   end

   assign beat_o    = beat_q;
   assign valid_o   = valid_q;
   assign last_o    = valid_q && (beat_q == mode_i.last_idx);
   assign illegal_o = illegal_q;

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
   import bseq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [WIN_W-1:0] beat_i,
   input  logic [WIN_W-1:0] mask_i,
   input  logic             interleave_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] base_q;
   logic [WIN_W-1:0] seq_low;
   logic [WIN_W-1:0] ilv_low;
   logic [WIN_W-1:0] sel_low;

   always_ff @(posedge clk) begin
      if (rst)
         base_q <= '0;
      else if (capture_i)
         base_q <= start_col_i;
   end

   // The carry past the window is dropped bit by bit by the mask below.
   assign seq_low = base_q[WIN_W-1:0] + beat_i;
   assign ilv_low = base_q[WIN_W-1:0] ^ beat_i;
   assign sel_low = interleave_i ? ilv_low : seq_low;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      if (b < WIN_W) begin : g_win
         assign col_o[b] = mask_i[b] ? sel_low[b] : base_q[b];
      end else begin : g_hold
         assign col_o[b] = base_q[b];
      end
   end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bseq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mr_load_i,
   input  logic [3:0]       mr_value_i,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             illegal_o
);

   if (COL_W < WIN_W + 1) begin : g_bad_width
      $error("burst_col_seq: COL_W must exceed the 3-bit burst window");
   end

   bmode_t           mode;
   logic             capture;
   logic [WIN_W-1:0] beat;
   logic             valid_int;

   bseq_mode_reg u_mode (
      .clk     (clk),
      .rst     (rst),
      .load_i  (mr_load_i),
      .busy_i  (valid_int),
      .value_i (mr_value_i),
      .mode_o  (mode)
   );

   bseq_beat_ctr u_ctr (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start_i),
      .mode_i    (mode),
      .capture_o (capture),
      .beat_o    (beat),
      .valid_o   (valid_int),
      .last_o    (last_o),
      .illegal_o (illegal_o)
   );

   bseq_addr_gen #(.COL_W(COL_W)) u_addr (
      .clk          (clk),
      .rst          (rst),
      .capture_i    (capture),
      .start_col_i  (start_col_i),
      .beat_i       (beat),
      .mask_i       (mode.mask),
      .interleave_i (mode.interleave),
      .col_o        (col_o)
   );

   assign valid_o = valid_int;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             illegal_o
);

   // R9: the final-beat flag only accompanies a valid beat
   a_r9_last_in_burst: assert property (@(posedge clk) disable iff (rst)
      last_o |-> valid_o);

   // R9: valid falls right after the final beat
   a_r9_end_after_last: assert property (@(posedge clk) disable iff (rst)
      last_o |=> !valid_o);

   // R2: a burst does not stop before its final beat
   a_r2_no_early_stop: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !last_o) |=> valid_o);

   // R9: a burst begins only after a sampled start
   a_r9_begin_on_start: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_o) |-> $past(start_i));

   // R3: a refused start yields no beat
   a_r3_illegal_no_beat: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> !valid_o);

   // R3: the illegal pulse follows a start
   a_r3_illegal_after_start: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> $past(start_i));

   // R6: bits above the widest window never move inside a burst
   a_r6_upper_hold: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !last_o) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

endmodule

bind burst_col_seq bseq_checker #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start_i   (start_i),
   .col_o     (col_o),
   .valid_o   (valid_o),
   .last_o    (last_o),
   .illegal_o (illegal_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             mr_load_i = 1'b0;
   logic [3:0]       mr_value_i = '0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;
   logic             illegal_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
      .clk(clk), .rst(rst), .mr_load_i(mr_load_i), .mr_value_i(mr_value_i),
      .start_i(start_i), .start_col_i(start_col_i), .col_o(col_o),
      .valid_o(valid_o), .last_o(last_o), .illegal_o(illegal_o));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int bl_of(input logic [2:0] code);
      case (code)
         3'b001:  return 2;
         3'b010:  return 4;
         3'b011:  return 8;
         default: return 0;
      endcase
   endfunction

   function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
         input int bl, input logic ilv, input int i);
      logic [COL_W-1:0] mask;
      logic [COL_W-1:0] low;
      mask = COL_W'(bl - 1);
      low  = ilv ? (s ^ COL_W'(i)) : (s + COL_W'(i));
      return (s & ~mask) | (low & mask);
   endfunction

   task automatic load_mode(input logic [3:0] v);
      mr_load_i  = 1'b1;
      mr_value_i = v;
      @(negedge clk);
      mr_load_i  = 1'b0;
   endtask

   // Starts a burst under the stored mode; expects length bl (0 = refused).
   task automatic run_burst(input string req, input int bl, input logic ilv,
         input logic [COL_W-1:0] col, input logic mid_load, input logic mid_start);
      start_i     = 1'b1;
      start_col_i = col;
      @(negedge clk);
      start_i     = 1'b0;
      if (bl == 0) begin
         chk({req, " R3 illegal pulse"}, int'(illegal_o), 1);
         chk({req, " R3 no beat"}, int'(valid_o), 0);
         @(negedge clk);
         chk({req, " R3 pulse one cycle"}, int'(illegal_o), 0);
         chk({req, " R3 still no beat"}, int'(valid_o), 0);
         return;
      end
      for (int i = 0; i < bl; i++) begin
         chk({req, " R2 valid"}, int'(valid_o), 1);
         chk({req, " R4 R5 R6 column"}, int'(col_o), int'(exp_col(col, bl, ilv, i)));
         chk({req, " R9 last"}, int'(last_o), int'(i == bl - 1));
         chk({req, " R3 no illegal"}, int'(illegal_o), 0);
         if (i == 0 && mid_load) begin
            mr_load_i  = 1'b1;
            mr_value_i = 4'b1001;
         end
         if (i == 0 && mid_start) begin
            start_i     = 1'b1;
            start_col_i = ~col;
         end
         @(negedge clk);
         mr_load_i = 1'b0;
         start_i   = 1'b0;
      end
      chk({req, " R9 valid falls after last"}, int'(valid_o), 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 valid after reset", int'(valid_o), 0);
      chk("R1 last after reset", int'(last_o), 0);
      chk("R1 illegal after reset", int'(illegal_o), 0);
      run_burst("R1 start with reset mode", 0, 1'b0, 10'h155, 1'b0, 1'b0);

      // Directed corners: wrap at the window top, upper bits held.
      load_mode(4'b0011); run_burst("R4 seq bl8 wrap", 8, 1'b0, 10'h3FD, 1'b0, 1'b0);
      load_mode(4'b1011); run_burst("R5 ilv bl8", 8, 1'b1, 10'h2A6, 1'b0, 1'b0);
      load_mode(4'b0010); run_burst("R4 seq bl4 wrap", 4, 1'b0, 10'h0F7, 1'b0, 1'b0);
      load_mode(4'b1010); run_burst("R5 ilv bl4", 4, 1'b1, 10'h10E, 1'b0, 1'b0);
      load_mode(4'b0001); run_burst("R6 seq bl2 no carry", 4'd2, 1'b0, 10'h1FF, 1'b0, 1'b0);
      load_mode(4'b1001); run_burst("R5 ilv bl2", 2, 1'b1, 10'h001, 1'b0, 1'b0);
      load_mode(4'b0100); run_burst("R3 code 100", 0, 1'b0, 10'h020, 1'b0, 1'b0);
      load_mode(4'b1111); run_burst("R3 code 111", 0, 1'b1, 10'h020, 1'b0, 1'b0);

      // R7: load during a burst is dropped; the next burst keeps length 8.
      load_mode(4'b0011);
      run_burst("R7 burst with mid load", 8, 1'b0, 10'h0C5, 1'b1, 1'b0);
      run_burst("R7 later burst unchanged", 8, 1'b0, 10'h0C2, 1'b0, 1'b0);
      // R8: a start mid burst leaves it unchanged.
      run_burst("R8 burst with mid start", 8, 1'b0, 10'h213, 1'b0, 1'b1);
      chk("R8 no extra burst", int'(valid_o), 0);

      for (int n = 0; n < 60; n++) begin
         logic [3:0]       v;
         logic [COL_W-1:0] c;
         v = 4'($urandom);
         c = COL_W'($urandom);
         load_mode(v);
         run_burst("R2 random", bl_of(v[2:0]), v[3], c, 1'b0, 1'b0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule